// File: doc/BRIEF.md
# UART FIFO Pair with Trigger Control

This block holds the byte buffers of one serial channel: a transmit FIFO filled by the host and drained by the transmit shifter, and a receive FIFO filled by the receive shifter and drained by the host. Each FIFO is 64 bytes deep by default, and each shows its fill level on a count output. A single write-only control byte sets up both FIFOs. It turns them on or off, empties either one, picks one of two ready-signalling modes, and selects the fill thresholds at which data movement is requested.

The ready outputs are the request lines for a DMA engine or a poll loop. In single-transfer mode they report the simplest conditions: the receive side holds any data, or the transmit side is empty. In block-transfer mode they report the programmed thresholds. The transmit threshold field is protected: it is loaded only when the enhanced-function input is high during the write. A flush empties a FIFO and zeroes its count. It leaves the last byte already handed to the shifter or host unchanged on the pop data output.

Top module: `uart_fifo_pair`

## Requirements
- R1: Each FIFO accepts up to DEPTH (64) bytes while enabled. A push into a full FIFO is dropped, and its count output never exceeds DEPTH.
- R2: Control bits [7:6] set the receive threshold: 0 gives 8 bytes, 1 gives 16, 2 gives DEPTH-8 (56) and 3 gives DEPTH-4 (60). The threshold is met when rx_count is at least that value.
- R3: Control bits [5:4] set the transmit threshold in free slots: 0 gives 8, 1 gives 16, 2 gives DEPTH/2 (32) and 3 gives DEPTH-8 (56). The threshold is met when DEPTH-tx_count is at least that value. The field is loaded only when enh_en is high during the write; otherwise the previous setting is kept.
- R4: With control bit [3]=0 (single-transfer mode), rx_ready is 1 exactly when rx_count is nonzero, and tx_ready is 1 exactly when tx_count is zero.
- R5: With control bit [3]=1 (block-transfer mode) and the FIFOs enabled, rx_ready and tx_ready follow the receive and transmit thresholds.
- R6: A write with control bit [2]=1 empties the transmit FIFO within that write cycle, and tx_count reads 0 one cycle later. A push or pop in that same cycle is ignored. tx_pop_data keeps its value, and the receive side is unaffected.
- R7: A write with control bit [1]=1 does the same for the receive FIFO: it is emptied, rx_count reads 0, and rx_pop_data keeps its value. The transmit side is unaffected.
- R8: Control bit [0] enables the FIFOs. It is 0 after reset. While it is 0, each FIFO holds at most one byte and both ready outputs use the single-transfer rules. Any write that changes bit [0] empties both FIFOs.
- R9: A receive push that finds the receive FIFO full sets rx_overrun, which stays 1 until reset.
- R10: A pop from an empty FIFO leaves its count at 0 and its pop data unchanged.
- R11: Bytes leave each FIFO in the order they entered. The popped byte appears on the pop data output in the cycle after the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_data | input | 8 | Control byte |
| enh_en | input | 1 | Allows the transmit threshold field to load |
| tx_push | input | 1 | Host writes a byte into the transmit FIFO |
| tx_push_data | input | 8 | Byte written by the host |
| tx_pop | input | 1 | Transmit shifter takes a byte |
| tx_pop_data | output | 8 | Last byte taken by the transmit shifter |
| tx_count | output | 7 | Bytes held in the transmit FIFO |
| tx_ready | output | 1 | Transmit request line |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_push_data | input | 8 | Byte delivered by the receive shifter |
| rx_pop | input | 1 | Host reads a byte |
| rx_pop_data | output | 8 | Last byte read by the host |
| rx_count | output | 7 | Bytes held in the receive FIFO |
| rx_ready | output | 1 | Receive request line |
| rx_overrun | output | 1 | Sticky receive overflow flag |

## Verification
A control write that flushes a FIFO can fall in the same clock cycle as a push, or as a push and a pop, on that same FIFO. The bench provokes this on the transmit side with a flush plus a push, and on the receive side with a flush plus a push plus a pop. Each collision is judged by three observations: the count reads zero, the pop data output keeps the byte it held before, and the other direction's count is untouched. A byte pushed and popped after the transmit collision then shows that the byte offered during the flush never entered the FIFO.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  typedef enum logic {
    DMA_SINGLE = 1'b0,
    DMA_BLOCK  = 1'b1
  } dma_mode_e;

  // receive threshold in stored bytes
  function automatic int unsigned rx_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return depth - 8;
      default: return depth - 4;
    endcase
  endfunction

  // transmit threshold in free slots
  function automatic int unsigned tx_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return depth / 2;
      default: return depth - 8;
    endcase
  endfunction

endpackage

// File: rtl/fifo_ctrl_reg.sv
module fifo_ctrl_reg
  import uart_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       enh_en,
  output logic       fifo_en,
  output dma_mode_e  dma_mode,
  output logic [1:0] rx_sel,
  output logic [1:0] tx_sel,
  output logic       tx_flush,
  output logic       rx_flush
);

  localparam int BIT_EN    = 0;
  localparam int BIT_RXCLR = 1;
  localparam int BIT_TXCLR = 2;
  localparam int BIT_DMA   = 3;
  localparam int FLD_TX    = 4;
  localparam int FLD_RX    = 6;

  logic en_change;

  assign en_change = wr_en && (wr_data[BIT_EN] != fifo_en);
  assign tx_flush  = (wr_en && wr_data[BIT_TXCLR]) || en_change;
  assign rx_flush  = (wr_en && wr_data[BIT_RXCLR]) || en_change;

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_en  <= 1'b0;
      dma_mode <= DMA_SINGLE;
      rx_sel   <= 2'd0;
      tx_sel   <= 2'd0;
    end else if (wr_en) begin
      fifo_en  <= wr_data[BIT_EN];
      dma_mode <= dma_mode_e'(wr_data[BIT_DMA]);
      rx_sel   <= wr_data[FLD_RX +: 2];
      if (enh_en) tx_sel <= wr_data[FLD_TX +: 2];
    end
  end

  AST_TXSEL_HELD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !enh_en) |=> (tx_sel == $past(tx_sel))); // R3

  AST_RXSEL_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rx_sel == $past(wr_data[FLD_RX +: 2]))); // R2

endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       limit_one,
  input  logic                       push,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  output logic [DW-1:0]              pop_data,
  output logic [$clog2(DEPTH+1)-1:0] count
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cap;
  logic          do_push, do_pop;

  assign cap     = limit_one ? CW'(1) : CW'(DEPTH);
  assign do_push = push && !flush && (count < cap);
  assign do_pop  = pop && !flush && (count != '0);

  // storage: write port and registered read port, RAM friendly
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)         pop_data <= '0;
    else if (do_pop) pop_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R1

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0)); // R6

  AST_FLUSH_KEEPS_OUT: assert property (@(posedge clk) disable iff (rst)
    flush |=> $stable(pop_data)); // R7

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && count == '0) |=> ($stable(pop_data) && count == '0)); // R10

  AST_SINGLE_SLOT: assert property (@(posedge clk) disable iff (rst)
    limit_one |-> (count <= CW'(1))); // R8

endmodule

// File: rtl/fifo_ready_gen.sv
module fifo_ready_gen
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                       fifo_en,
  input  dma_mode_e                  dma_mode,
  input  logic [1:0]                 rx_sel,
  input  logic [1:0]                 tx_sel,
  input  logic [$clog2(DEPTH+1)-1:0] rx_count,
  input  logic [$clog2(DEPTH+1)-1:0] tx_count,
  output logic                       rx_ready,
  output logic                       tx_ready
);

  logic rx_hit, tx_hit;

  always_comb begin
    rx_hit = 32'(rx_count) >= rx_level(rx_sel, DEPTH);
    tx_hit = (32'(DEPTH) - 32'(tx_count)) >= tx_level(tx_sel, DEPTH);
    if (fifo_en && dma_mode == DMA_BLOCK) begin
      rx_ready = rx_hit;
      tx_ready = tx_hit;
    end else begin
      rx_ready = (rx_count != '0);
      tx_ready = (tx_count == '0);
    end
  end

endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [7:0]                 cfg_data,
  input  logic                       enh_en,
  input  logic                       tx_push,
  input  logic [DW-1:0]              tx_push_data,
  input  logic                       tx_pop,
  output logic [DW-1:0]              tx_pop_data,
  output logic [$clog2(DEPTH+1)-1:0] tx_count,
  output logic                       tx_ready,
  input  logic                       rx_push,
  input  logic [DW-1:0]              rx_push_data,
  input  logic                       rx_pop,
  output logic [DW-1:0]              rx_pop_data,
  output logic [$clog2(DEPTH+1)-1:0] rx_count,
  output logic                       rx_ready,
  output logic                       rx_overrun
);

  localparam int CW = $clog2(DEPTH+1);

  logic      fifo_en, tx_flush, rx_flush;
  dma_mode_e dma_mode;
  logic [1:0] rx_sel, tx_sel;
  logic [CW-1:0] rx_cap;

  fifo_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_we),
    .wr_data  (cfg_data),
    .enh_en   (enh_en),
    .fifo_en  (fifo_en),
    .dma_mode (dma_mode),
    .rx_sel   (rx_sel),
    .tx_sel   (tx_sel),
    .tx_flush (tx_flush),
    .rx_flush (rx_flush)
  );

  byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
    .clk       (clk),
    .rst       (rst),
    .flush     (tx_flush),
    .limit_one (!fifo_en),
    .push      (tx_push),
    .push_data (tx_push_data),
    .pop       (tx_pop),
    .pop_data  (tx_pop_data),
    .count     (tx_count)
  );

  byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
    .clk       (clk),
    .rst       (rst),
    .flush     (rx_flush),
    .limit_one (!fifo_en),
    .push      (rx_push),
    .push_data (rx_push_data),
    .pop       (rx_pop),
    .pop_data  (rx_pop_data),
    .count     (rx_count)
  );

  fifo_ready_gen #(.DEPTH(DEPTH)) u_ready (
    .fifo_en  (fifo_en),
    .dma_mode (dma_mode),
    .rx_sel   (rx_sel),
    .tx_sel   (tx_sel),
    .rx_count (rx_count),
    .tx_count (tx_count),
    .rx_ready (rx_ready),
    .tx_ready (tx_ready)
  );

  // sticky overflow on the receive side
  assign rx_cap = fifo_en ? CW'(DEPTH) : CW'(1);

  always_ff @(posedge clk) begin
    if (rst) rx_overrun <= 1'b0;
    else if (rx_push && !rx_flush && rx_count >= rx_cap) rx_overrun <= 1'b1;
  end

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    rx_overrun |=> rx_overrun); // R9

  AST_SINGLE_TX_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (dma_mode == DMA_SINGLE && tx_ready) |-> (tx_count == '0)); // R4

endmodule

// File: tb/test_uart_fifo_pair.sv
module test_uart_fifo_pair;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1;
  logic       cfg_we = 1'b0, enh_en = 1'b0;
  logic [7:0] cfg_data = '0;
  logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0] tx_push_data = '0, rx_push_data = '0;
  logic [7:0] tx_pop_data, rx_pop_data;
  logic [6:0] tx_count, rx_count;
  logic       tx_ready, rx_ready, rx_overrun;

  uart_fifo_pair i_uart_fifo_pair (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_data(cfg_data), .enh_en(enh_en),
    .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop),
    .tx_pop_data(tx_pop_data), .tx_count(tx_count), .tx_ready(tx_ready),
    .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop),
    .rx_pop_data(rx_pop_data), .rx_count(rx_count), .rx_ready(rx_ready),
    .rx_overrun(rx_overrun)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] rx_mdl[$], tx_mdl[$], rx_exp[$], tx_exp[$];
  logic [7:0] rx_last = '0, tx_last = '0;
  bit en_m = 0;
  event rx_ev, tx_ev;

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // scoreboard monitors: compare popped bytes against the expected queue
  always begin
    @(rx_ev);
    @(negedge clk);
    chk("R11", "rx pop order", 16'(rx_pop_data), 16'(rx_exp.pop_front()));
  end

  always begin
    @(tx_ev);
    @(negedge clk);
    chk("R11", "tx pop order", 16'(tx_pop_data), 16'(tx_exp.pop_front()));
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rx_mdl.delete(); tx_mdl.delete();
    rx_last = '0; tx_last = '0; en_m = 0;
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [7:0] d, input logic enh);
    cfg_we = 1'b1; cfg_data = d; enh_en = enh;
    if (d[0] != en_m) begin rx_mdl.delete(); tx_mdl.delete(); end
    en_m = d[0];
    if (d[2]) tx_mdl.delete();
    if (d[1]) rx_mdl.delete();
    @(negedge clk);
    cfg_we = 1'b0; enh_en = 1'b0;
  endtask

  task automatic push(input bit is_tx, input logic [7:0] b);
    int cap;
    cap = en_m ? 64 : 1;
    if (is_tx) begin
      tx_push = 1'b1; tx_push_data = b;
      if (tx_mdl.size() < cap) tx_mdl.push_back(b);
    end else begin
      rx_push = 1'b1; rx_push_data = b;
      if (rx_mdl.size() < cap) rx_mdl.push_back(b);
    end
    @(negedge clk);
    tx_push = 1'b0; rx_push = 1'b0;
  endtask

  task automatic pop(input bit is_tx);
    if (is_tx) begin
      tx_pop = 1'b1;
      if (tx_mdl.size() > 0) tx_last = tx_mdl.pop_front();
      tx_exp.push_back(tx_last);
      @(posedge clk); -> tx_ev;
    end else begin
      rx_pop = 1'b1;
      if (rx_mdl.size() > 0) rx_last = rx_mdl.pop_front();
      rx_exp.push_back(rx_last);
      @(posedge clk); -> rx_ev;
    end
    @(negedge clk);
    tx_pop = 1'b0; rx_pop = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lvl;
    do_reset();
    // reset state
    chk("R8", "rx_count after reset", 16'(rx_count), 16'd0);
    chk("R8", "tx_count after reset", 16'(tx_count), 16'd0);
    chk("R4", "rx_ready after reset", 16'(rx_ready), 16'd0);
    chk("R4", "tx_ready after reset", 16'(tx_ready), 16'd1);
    chk("R9", "rx_overrun after reset", 16'(rx_overrun), 16'd0);

    // disabled: single-byte holding
    push(0, 8'h11); push(0, 8'h22);
    chk("R8", "rx depth one", 16'(rx_count), 16'd1);
    chk("R9", "overrun when disabled and full", 16'(rx_overrun), 16'd1);
    pop(0);
    push(1, 8'h33); push(1, 8'h44);
    chk("R8", "tx depth one", 16'(tx_count), 16'd1);
    pop(1);
    @(negedge clk);

    do_reset();
    cfg_write(8'h01, 1'b1);
    for (int i = 0; i < 64; i++) push(0, 8'(i * 3 + 1));
    chk("R1", "rx full count", 16'(rx_count), 16'd64);
    chk("R9", "no overrun before full push", 16'(rx_overrun), 16'd0);
    push(0, 8'hEE);
    chk("R1", "rx count after drop", 16'(rx_count), 16'd64);
    chk("R9", "overrun set", 16'(rx_overrun), 16'd1);
    for (int i = 0; i < 65; i++) push(1, 8'(i + 100));
    chk("R1", "tx count capped", 16'(tx_count), 16'd64);
    for (int i = 0; i < 5; i++) pop(0);
    @(negedge clk);
    chk("R1", "rx count after pops", 16'(rx_count), 16'd59);
    chk("R4", "rx_ready single mode with data", 16'(rx_ready), 16'd1);
    chk("R4", "tx_ready single mode not empty", 16'(tx_ready), 16'd0);
    chk("R9", "overrun stays set", 16'(rx_overrun), 16'd1);

    // transmit flush colliding with a push
    pop(1);
    @(negedge clk);
    tx_push = 1'b1; tx_push_data = 8'h99;
    cfg_we = 1'b1; cfg_data = 8'h05; enh_en = 1'b1;
    tx_mdl.delete();
    @(negedge clk);
    tx_push = 1'b0; cfg_we = 1'b0; enh_en = 1'b0;
    chk("R6", "tx count after flush", 16'(tx_count), 16'd0);
    chk("R6", "tx pop data kept", 16'(tx_pop_data), 16'(tx_last));
    chk("R6", "rx untouched by tx flush", 16'(rx_count), 16'd59);
    push(1, 8'hA1);
    pop(1);
    push(1, 8'hA2);

    // receive flush colliding with a push and a pop
    rx_push = 1'b1; rx_push_data = 8'h55; rx_pop = 1'b1;
    cfg_we = 1'b1; cfg_data = 8'h03; enh_en = 1'b1;
    rx_mdl.delete();
    @(negedge clk);
    rx_push = 1'b0; rx_pop = 1'b0; cfg_we = 1'b0; enh_en = 1'b0;
    chk("R7", "rx count after flush", 16'(rx_count), 16'd0);
    chk("R7", "rx pop data kept", 16'(rx_pop_data), 16'(rx_last));
    chk("R7", "tx untouched by rx flush", 16'(tx_count), 16'd1);

    // pop from empty receive FIFO
    pop(0);
    @(negedge clk);
    chk("R10", "rx count stays zero", 16'(rx_count), 16'd0);
    chk("R10", "rx data unchanged", 16'(rx_pop_data), 16'(rx_last));

    // receive thresholds in block mode
    for (int s = 0; s < 4; s++) begin
      lvl = (s == 0) ? 8 : (s == 1) ? 16 : (s == 2) ? 56 : 60;
      cfg_write(8'((s << 6) | 8'h0B), 1'b1);
      for (int i = 0; i < lvl - 1; i++) push(0, 8'(i));
      chk("R2", "rx below threshold", 16'(rx_ready), 16'd0);
      push(0, 8'hC0);
      chk("R5", "rx at threshold", 16'(rx_ready), 16'd1);
    end

    // transmit thresholds in block mode
    for (int s = 0; s < 4; s++) begin
      lvl = (s == 0) ? 8 : (s == 1) ? 16 : (s == 2) ? 32 : 56;
      cfg_write(8'((s << 4) | 8'h0D), 1'b1);
      for (int i = 0; i < 64 - lvl; i++) push(1, 8'(i));
      chk("R3", "tx free equals threshold", 16'(tx_ready), 16'd1);
      push(1, 8'hC1);
      chk("R5", "tx free below threshold", 16'(tx_ready), 16'd0);
    end

    // transmit threshold write without enh_en is ignored
    cfg_write(8'h0D, 1'b1);
    cfg_write(8'h39, 1'b0);
    for (int i = 0; i < 56; i++) push(1, 8'(i));
    chk("R3", "tx threshold kept at 8", 16'(tx_ready), 16'd1);
    push(1, 8'hC2);
    chk("R3", "tx below kept threshold", 16'(tx_ready), 16'd0);

    // single-transfer mode rules
    cfg_write(8'h07, 1'b1);
    chk("R4", "tx_ready when empty", 16'(tx_ready), 16'd1);
    chk("R4", "rx_ready when empty", 16'(rx_ready), 16'd0);
    push(0, 8'h5A);
    push(1, 8'hA5);
    chk("R4", "rx_ready one byte", 16'(rx_ready), 16'd1);
    chk("R4", "tx_ready one byte", 16'(tx_ready), 16'd0);

    // disable flushes; disabled mode uses single-transfer rules
    cfg_write(8'h00, 1'b1);
    chk("R8", "rx flushed on disable", 16'(rx_count), 16'd0);
    chk("R8", "tx flushed on disable", 16'(tx_count), 16'd0);
    cfg_write(8'h08, 1'b1);
    push(0, 8'h61); push(0, 8'h62);
    chk("R8", "rx depth one again", 16'(rx_count), 16'd1);
    chk("R8", "rx_ready single rule while disabled", 16'(rx_ready), 16'd1);
    pop(0);
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule